// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Cell

This block is one logic cell of a sum-of-products programmable logic device, together with the shared signal bus that feeds it. The bus is built from the dedicated inputs, the feedback signals of the peer cells, and this cell's own feedback. Each bus signal is available in true and complement form. A flat configuration word programs eight product terms and one control term. The product terms are ORed and pass through a polarity XOR. The result then leaves the cell either directly or through a register whose flip-flop type can be configured.

Further configuration bits choose the following:
- the register type (D, T, JK or SR);
- whether the register clock comes from one of two global clocks or from the control term;
- whether the output enable comes from the control term or is held on;
- whether the cell's feedback to the bus is its register output or the value read back from its I/O pin.

An active-high asynchronous clear forces the register to 0. Configuration is meant to be changed only while the clear is asserted.

Top module: `plc_cell`

## Requirements
- R1: The bus has N_SIG = N_DED + N_PEER + 1 signals. Bits 0..N_DED-1 are `ded_in`, the next N_PEER bits are `peer_fb`, and the top bit is this cell's own `fb_out`. Each term has 2 code bits per bus signal. The code for signal s of term t sits at `cfg_and[(t*N_SIG+s)*2 +: 2]`, and the control term uses `cfg_ctl[s*2 +: 2]`. Code 00 leaves the signal out, 01 uses its true form, 10 uses its complement, and 11 forces the whole term to 0. A term whose codes are all 00 evaluates to 1.
- R2: In D (`cfg_ff`=00) and T (01) modes the sum is the OR of all eight terms. In JK (10) and SR (11) modes the sum is the OR of terms 0..5. The second register input is the OR of terms 6 and 7.
- R3: With `cfg_inv`=1 the sum is inverted before it reaches the register or the output. With `cfg_inv`=0 it passes unchanged.
- R4: With `cfg_reg`=0, `pin_out` equals the polarity-adjusted sum, combinationally.
- R5: With `cfg_reg`=1, `pin_out` equals the register output.
- R6: On a register clock edge, D mode loads the polarity-adjusted sum. T mode inverts the register when the sum is 1 and holds it otherwise.
- R7: In JK mode, with J the polarity-adjusted sum and K the second input, 10 sets, 01 clears, 11 toggles and 00 holds.
- R8: In SR mode, with S the polarity-adjusted sum and R the second input, 10 sets and 01 clears. Both 11 and 00 hold.
- R9: With `cfg_array_clk`=0, `pin_oe` equals the control term. The register is clocked by the rising edge of `gclk[cfg_gclk_sel]`.
- R10: With `cfg_array_clk`=1, `pin_oe` is 1. The register is clocked by the rising edge of the control term, and the global clocks have no effect.
- R11: `fb_out` equals the register output when `cfg_fb_pin`=0. It equals `pin_in`, the externally driven pin value, when `cfg_fb_pin`=1. This value is what the top bus bit carries.
- R12: While `aclr` is 1 the register is 0, with no clock needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 2 | Two global clocks |
| aclr | input | 1 | Asynchronous register clear, active high |
| ded_in | input | N_DED | Dedicated inputs onto the bus |
| peer_fb | input | N_PEER | Feedback signals of the other cells |
| pin_in | input | 1 | Value read back from this cell's I/O pin |
| cfg_and | input | N_PT*2*N_SIG | Codes of the eight product terms |
| cfg_ctl | input | 2*N_SIG | Codes of the control term |
| cfg_inv | input | 1 | Sum polarity inversion |
| cfg_reg | input | 1 | 1 selects registered output, 0 combinational |
| cfg_ff | input | 2 | Register type: 00 D, 01 T, 10 JK, 11 SR |
| cfg_array_clk | input | 1 | 1 clocks from the control term and holds OE on |
| cfg_gclk_sel | input | 1 | Which global clock is used when not array clocked |
| cfg_fb_pin | input | 1 | 1 feeds back the pin value, 0 the register |
| pin_out | output | 1 | Cell output toward the pin |
| pin_oe | output | 1 | Pin output enable |
| fb_out | output | 1 | Selected feedback signal |

## Verification
The register properties assume that configuration changes only while `aclr` is high. They also assume that the register clock is glitch-free, so that each rising edge of the selected clock is a single clean edge. The stimulus reconfigures the cell only inside a clear pulse. In array-clock mode the bench programs the control term as the true form of the top dedicated input alone, and keeps that input out of every data term. This lets each clock edge be raised by itself, after the data inputs have settled. All other inputs change on the falling edge of the bench clock, away from every global clock edge.

// File: rtl/plc_cell.sv
module plc_cell #(
  parameter int N_DED   = 12,
  parameter int N_PEER  = 23,
  parameter int N_PT    = 8,
  parameter int N_SPLIT = 2,
  localparam int N_SIG  = N_DED + N_PEER + 1,
  localparam int CW     = 2 * N_SIG,
  localparam int N_LO   = N_PT - N_SPLIT
) (
  input  logic [1:0]         gclk,
  input  logic               aclr,
  input  logic [N_DED-1:0]   ded_in,
  input  logic [N_PEER-1:0]  peer_fb,
  input  logic               pin_in,
  input  logic [N_PT*CW-1:0] cfg_and,
  input  logic [CW-1:0]      cfg_ctl,
  input  logic               cfg_inv,
  input  logic               cfg_reg,
  input  logic [1:0]         cfg_ff,
  input  logic               cfg_array_clk,
  input  logic               cfg_gclk_sel,
  input  logic               cfg_fb_pin,
  output logic               pin_out,
  output logic               pin_oe,
  output logic               fb_out
);

  localparam logic [1:0] FF_D = 2'b00, FF_T = 2'b01, FF_JK = 2'b10, FF_SR = 2'b11;

  logic [N_SIG-1:0]       bus;
  logic [(N_PT+1)*CW-1:0] codes;
  logic [N_PT:0]          term;
  logic                   sum_lo, sum_hi, sum, d_in, aux, ctl;
  logic                   q, q_next, reg_clk;

  assign bus   = {fb_out, peer_fb, ded_in};
  assign codes = {cfg_ctl, cfg_and};

  for (genvar t = 0; t <= N_PT; t++) begin : g_term
    logic [N_SIG-1:0] lit;
    for (genvar s = 0; s < N_SIG; s++) begin : g_lit
      logic [1:0] c;
      assign c      = codes[(t*N_SIG+s)*2 +: 2];
      assign lit[s] = (c == 2'b00) | ((c == 2'b01) & bus[s]) | ((c == 2'b10) & ~bus[s]);
    end
    assign term[t] = &lit;
  end

  assign ctl    = term[N_PT];
  assign sum_lo = |term[N_LO-1:0];
  assign sum_hi = |term[N_PT-1:N_LO];
  assign sum    = cfg_ff[1] ? sum_lo : (sum_lo | sum_hi);
  assign d_in   = sum ^ cfg_inv;
  assign aux    = sum_hi;

  always_comb begin
    case (cfg_ff)
      FF_D:    q_next = d_in;
      FF_T:    q_next = q ^ d_in;
      FF_JK:   q_next = (d_in & aux) ? ~q : (d_in | (q & ~aux));
      FF_SR:   q_next = (d_in ^ aux) ? d_in : q;
      default: q_next = q;
    endcase
  end

  assign reg_clk = cfg_array_clk ? ctl : gclk[cfg_gclk_sel];

  always_ff @(posedge reg_clk or posedge aclr) begin
    if (aclr) q <= 1'b0;
    else      q <= q_next;
  end

  assign pin_out = cfg_reg ? q : d_in;
  assign pin_oe  = cfg_array_clk | ctl;
  assign fb_out  = cfg_fb_pin ? pin_in : q;

endmodule

module plc_cell_chk (
  input logic       reg_clk,
  input logic       gclk0,
  input logic       aclr,
  input logic       q,
  input logic       d_in,
  input logic       aux,
  input logic [1:0] cfg_ff,
  input logic       cfg_array_clk,
  input logic       pin_oe
);

  logic fresh;

  always_ff @(posedge reg_clk or posedge aclr) begin
    if (aclr) fresh <= 1'b1;
    else      fresh <= 1'b0;
  end

  a_r6_d_load: assert property (@(posedge reg_clk) disable iff (aclr)
    (cfg_ff == 2'b00 && !fresh) |-> q == $past(d_in));

  a_r6_t_toggle: assert property (@(posedge reg_clk) disable iff (aclr)
    (cfg_ff == 2'b01 && !fresh) |-> q == ($past(q) ^ $past(d_in)));

  a_r7_jk_toggle: assert property (@(posedge reg_clk) disable iff (aclr)
    (cfg_ff == 2'b10 && !fresh && $past(d_in) && $past(aux)) |-> q != $past(q));

  a_r8_sr_hold: assert property (@(posedge reg_clk) disable iff (aclr)
    (cfg_ff == 2'b11 && !fresh && ($past(d_in) == $past(aux))) |-> q == $past(q));

  a_r10_oe_on: assert property (@(posedge gclk0) disable iff (aclr)
    cfg_array_clk |-> pin_oe);

endmodule

bind plc_cell plc_cell_chk u_chk (
  .reg_clk(reg_clk),
  .gclk0(gclk[0]),
  .aclr(aclr),
  .q(q),
  .d_in(d_in),
  .aux(aux),
  .cfg_ff(cfg_ff),
  .cfg_array_clk(cfg_array_clk),
  .pin_oe(pin_oe)
);

// File: tb/plc_cell_test.sv
module plc_cell_test;
  localparam int N_DED = 12, N_PEER = 23, N_PT = 8, N_SPLIT = 2;
  localparam int N_SIG = N_DED + N_PEER + 1, CW = 2 * N_SIG, CK = N_DED - 1;

  logic clk = 1'b0, gclk1 = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) gclk1 <= ~gclk1;

  logic aclr = 1'b0;
  logic [N_DED-1:0] ded_in = '0;
  logic [N_PEER-1:0] peer_fb = '0;
  logic pin_in = 1'b0;
  logic [N_PT*CW-1:0] c_and = '0;
  logic [CW-1:0] c_ctl = '0;
  logic inv = 0, rg = 0, arr = 0, gsel = 0, fbp = 0;
  logic [1:0] ff = 2'b00;
  logic pin_out, pin_oe, fb_out;
  logic mq = 1'b0;
  int checks = 0, fails = 0;

  plc_cell uut (
    .gclk({gclk1, clk}), .aclr(aclr), .ded_in(ded_in), .peer_fb(peer_fb), .pin_in(pin_in),
    .cfg_and(c_and), .cfg_ctl(c_ctl), .cfg_inv(inv), .cfg_reg(rg), .cfg_ff(ff),
    .cfg_array_clk(arr), .cfg_gclk_sel(gsel), .cfg_fb_pin(fbp),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic logic term_f(input logic [CW-1:0] cd, input logic [N_SIG-1:0] bus);
    for (int s = 0; s < N_SIG; s++) begin
      case (cd[s*2 +: 2])
        2'b01: if (!bus[s]) return 1'b0;
        2'b10: if (bus[s]) return 1'b0;
        2'b11: return 1'b0;
        default: ;
      endcase
    end
    return 1'b1;
  endfunction

  function automatic logic ff_next(input logic [1:0] m, input logic q, input logic a, input logic b);
    case (m)
      2'b00: return a;
      2'b01: return q ^ a;
      2'b10: return (a && b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
      default: return (a && !b) ? 1'b1 : ((!a && b) ? 1'b0 : q);
    endcase
  endfunction

  function automatic logic [CW-1:0] rand_codes(input bit no_ck);
    logic [CW-1:0] cd = '0;
    if ($urandom % 8 == 0) return cd;
    for (int s = 0; s < N_SIG; s++) begin
      int r = $urandom % 64;
      cd[s*2 +: 2] = (r == 0) ? 2'b11 : (r < 5) ? 2'b01 : (r < 9) ? 2'b10 : 2'b00;
    end
    if (no_ck) cd[CK*2 +: 2] = 2'b00;
    return cd;
  endfunction

  task automatic model(output logic ed, output logic ea, output logic ec);
    logic [N_SIG-1:0] bus;
    logic [N_PT-1:0] p;
    logic lo, hi;
    bus = {(fbp ? pin_in : mq), peer_fb, ded_in};
    for (int t = 0; t < N_PT; t++) p[t] = term_f(c_and[t*CW +: CW], bus);
    lo = |p[N_PT-N_SPLIT-1:0];
    hi = |p[N_PT-1:N_PT-N_SPLIT];
    ed = (ff[1] ? lo : (lo | hi)) ^ inv;
    ea = hi;
    ec = term_f(c_ctl, bus);
  endtask

  task automatic check_outs;
    logic ed, ea, ec;
    string ot;
    model(ed, ea, ec);
    if (!rg) ot = "R4";
    else case (ff)
      2'b00, 2'b01: ot = "R5 R6";
      2'b10: ot = "R5 R7";
      default: ot = "R5 R8";
    endcase
    chk(ot, "pin_out", pin_out, rg ? mq : ed);
    if (arr) chk("R10", "pin_oe", pin_oe, 1'b1);
    else     chk("R9", "pin_oe", pin_oe, ec);
    chk("R11", "fb_out", fb_out, fbp ? pin_in : mq);
  endtask

  task automatic step;
    logic ed, ea, ec;
    @(negedge clk);
    aclr = 1'b0;
    ded_in = N_DED'($urandom);
    peer_fb = N_PEER'($urandom);
    pin_in = 1'($urandom);
    if (arr) ded_in[CK] = 1'b0;
    #1 check_outs;
    model(ed, ea, ec);
    if (!arr) begin
      if (!gsel || !gclk1) mq = ff_next(ff, mq, ed, ea);
    end else begin
      ded_in[CK] = 1'b1;
      #1 mq = ff_next(ff, mq, ed, ea);
      check_outs;
      ded_in[CK] = 1'b0;
      #1 check_outs;
    end
  endtask

  task automatic new_trial;
    @(negedge clk);
    aclr = 1'b1;
    rg = 1'($urandom); ff = 2'($urandom); inv = 1'($urandom);
    gsel = 1'($urandom); fbp = 1'($urandom); arr = ($urandom % 3 == 0);
    for (int t = 0; t < N_PT; t++) c_and[t*CW +: CW] = rand_codes(arr);
    if (arr) begin
      c_ctl = '0;
      c_ctl[CK*2 +: 2] = 2'b01;
    end else c_ctl = rand_codes(1'b0);
    #1 mq = 1'b0;
    if (rg)   chk("R12", "pin_out in clear", pin_out, 1'b0);
    if (!fbp) chk("R12", "fb_out in clear", fb_out, 1'b0);
  endtask

  task automatic set_base;
    rg = 0; ff = 2'b00; inv = 0; arr = 0; gsel = 0; fbp = 0;
    c_and = '0;
    for (int t = 0; t < N_PT; t++) c_and[t*CW +: 2] = 2'b11;
    c_ctl = '0;
    ded_in = '0; peer_fb = '0; pin_in = 1'b0;
  endtask

  initial begin
    #1 aclr = 1'b1;
    set_base();
    rg = 1;
    #20;
    chk("R12", "reset pin_out", pin_out, 1'b0);
    chk("R12", "reset fb_out", fb_out, 1'b0);
    rg = 0;

    c_and[0 +: 2] = 2'b00;
    #1 chk("R1", "all-excluded term", pin_out, 1'b1);
    inv = 1;
    #1 chk("R3", "inverted sum", pin_out, 1'b0);
    inv = 0;
    c_and[0 +: 2] = 2'b01; ded_in[0] = 1'b1;
    #1 chk("R1", "true literal 1", pin_out, 1'b1);
    ded_in[0] = 1'b0;
    #1 chk("R1", "true literal 0", pin_out, 1'b0);
    c_and[0 +: 2] = 2'b10;
    #1 chk("R1", "complement literal", pin_out, 1'b1);
    c_and[0 +: 2] = 2'b11;
    #1 chk("R1", "force-zero code", pin_out, 1'b0);

    c_and[7*CW +: 2] = 2'b00;
    #1 chk("R2", "term7 in D sum", pin_out, 1'b1);
    ff = 2'b10;
    #1 chk("R2", "term7 left out of JK sum", pin_out, 1'b0);
    ff = 2'b11; inv = 1;
    #1 chk("R2", "term7 left out of SR sum", pin_out, 1'b1);
    ff = 2'b00; inv = 0;
    c_and[7*CW +: 2] = 2'b11;

    fbp = 1;
    c_and[(N_SIG-1)*2 +: 2] = 2'b01;
    c_and[0 +: 2] = 2'b00;
    pin_in = 1'b1;
    #1 chk("R11", "pin feedback on bus 1", pin_out, 1'b1);
    pin_in = 1'b0;
    #1 chk("R11", "pin feedback on bus 0", pin_out, 1'b0);

    set_base();
    c_ctl[0 +: 2] = 2'b01;
    #1 chk("R9", "OE from control term 0", pin_oe, 1'b0);
    ded_in[0] = 1'b1;
    #1 chk("R9", "OE from control term 1", pin_oe, 1'b1);
    ded_in[0] = 1'b0; arr = 1;
    #1 chk("R10", "OE held on", pin_oe, 1'b1);

    void'($urandom(32'h00C0FFEE));
    for (int n = 0; n < 400; n++) begin
      new_trial();
      for (int k = 0; k < 24; k++) step();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule